// File: doc/BRIEF.md
# Byte-Serial Variable-Length Instruction Decoder

This block takes a stream of instruction bytes, one byte per cycle under a valid/ready handshake. From that stream it builds complete instructions of 1, 2, 9 or 10 bytes and turns each one into a single decoded record. The upper nibble of the leading byte picks the instruction class, and the class alone fixes the length. The decoder then collects the optional register byte and the optional 8-byte constant. Constants are assembled least significant byte first.

Each record gives the class, the function code, the two register identifiers, the 64-bit constant, the length and an error flag. It also carries the address of the instruction and the address of the instruction that follows it. The address counter starts at a parameter value after reset and moves forward by the length of each instruction. A downstream stage that is not ready holds the current record in place and stops input acceptance, so no byte is ever lost.

Top module: `byte_insn_decoder`

## Requirements
- R1: The leading byte splits into class (bits 7:4) and function code (bits 3:0), reported on out_class and out_func.
- R2: Length by class: classes 0x0, 0x1 and 0x9 take 1 byte. Classes 0x2, 0x6, 0xA and 0xB take 2 bytes. Classes 0x7 and 0x8 take 9 bytes. Classes 0x3, 0x4 and 0x5 take 10 bytes. Classes 0xC to 0xF are treated as 1 byte.
- R3: For classes 0x2 to 0x6, 0xA and 0xB, the second byte gives out_ra (bits 7:4) and out_rb (bits 3:0). For all other classes both fields read 0xF, meaning no register.
- R4: Classes 0x7 and 0x8 carry 8 constant bytes directly after the leading byte. Classes 0x3 to 0x5 carry them after the register byte. The first constant byte is bits 7:0 of out_const. Instructions without a constant report out_const = 0.
- R5: A byte of 0x00 decodes as a 1-byte instruction of class 0 with no error.
- R6: out_err is set for any class from 0xC to 0xF. It is also set when the function code is above 6 for class 0x2 or 0x7, above 3 for class 0x6, or nonzero for any other class. The record is still emitted.
- R7: out_valid rises in the cycle after the final byte of an instruction is accepted. When out_ready is high it lasts exactly one cycle per record.
- R8: While out_valid is high and out_ready is low, in_ready is low and every record output holds steady.
- R9: The first record after reset has out_addr = START_ADDR. Each record has out_next_addr = out_addr + out_len, and the next record's out_addr equals the previous out_next_addr.
- R10: During reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Downstream takes the record |
| out_class | output | 4 | Instruction class |
| out_func | output | 4 | Function code |
| out_ra | output | 4 | First register identifier (0xF = none) |
| out_rb | output | 4 | Second register identifier (0xF = none) |
| out_const | output | 64 | Assembled constant |
| out_len | output | 4 | Instruction length in bytes |
| out_err | output | 1 | Illegal class or function code |
| out_addr | output | ADDR_W | Address of this instruction |
| out_next_addr | output | ADDR_W | Address of the following instruction |

## Verification
The stall assertions assume that out_ready is a plain level the downstream may drop at any cycle, and that in_valid with in_byte is only sampled at a clock edge. The assembler's index assertion assumes the stream is never cut off inside an instruction. The stimulus keeps to these assumptions. It drives in_valid, in_byte and out_ready only on the falling edge. It always completes each instruction it starts, and it leaves a byte pending on the input while the output is stalled.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  localparam int CONST_BYTES = 8;
  localparam int CONST_W     = CONST_BYTES * 8;
  localparam int LEN_W       = 4;
  localparam logic [3:0] NO_REG = 4'hF;

  typedef struct packed {
    logic [3:0]         cls;
    logic [3:0]         fn;
    logic [3:0]         ra;
    logic [3:0]         rb;
    logic [CONST_W-1:0] konst;
    logic [LEN_W-1:0]   len;
    logic               err;
  } insn_rec_t;

  function automatic logic [LEN_W-1:0] insn_length(input logic [3:0] cls);
    case (cls)
      4'h0, 4'h1, 4'h9:       insn_length = 4'd1;
      4'h2, 4'h6, 4'hA, 4'hB: insn_length = 4'd2;
      4'h7, 4'h8:             insn_length = 4'd9;
      4'h3, 4'h4, 4'h5:       insn_length = 4'd10;
      default:                insn_length = 4'd1;
    endcase
  endfunction

  function automatic logic has_reg_byte(input logic [3:0] cls);
    case (cls)
      4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB: has_reg_byte = 1'b1;
      default:                                   has_reg_byte = 1'b0;
    endcase
  endfunction

  function automatic logic insn_illegal(input logic [3:0] cls, input logic [3:0] fn);
    case (cls)
      4'h2, 4'h7: insn_illegal = (fn > 4'd6);
      4'h6:       insn_illegal = (fn > 4'd3);
      4'hC, 4'hD, 4'hE, 4'hF: insn_illegal = 1'b1;
      default:    insn_illegal = (fn != 4'd0);
    endcase
  endfunction

endpackage

// File: rtl/insn_head_decode.sv
module insn_head_decode
  import insn_dec_pkg::*;
(
  input  logic [7:0]       head,
  output logic [3:0]       cls,
  output logic [3:0]       fn,
  output logic [LEN_W-1:0] len,
  output logic             has_reg,
  output logic             err
);
  assign cls     = head[7:4];
  assign fn      = head[3:0];
  assign len     = insn_length(head[7:4]);
  assign has_reg = has_reg_byte(head[7:4]);
  assign err     = insn_illegal(head[7:4], head[3:0]);
endmodule

// File: rtl/insn_byte_assembler.sv
module insn_byte_assembler
  import insn_dec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  logic [7:0] byte_in,
  output logic      fin,
  output insn_rec_t rec
);
  logic [3:0]         idx_q;
  logic [7:0]         head_q;
  logic [7:0]         regs_q;
  logic [CONST_W-1:0] konst_q;

  logic               at_start;
  logic [7:0]         head_cur;
  logic [3:0]         cls_cur;
  logic [3:0]         fn_cur;
  logic [LEN_W-1:0]   len_cur;
  logic               has_reg_cur;
  logic               err_cur;
  logic               in_reg_slot;
  logic               in_const_slot;
  logic [2:0]         const_k;
  logic [7:0]         regs_nx;
  logic [CONST_W-1:0] konst_base;
  logic [CONST_W-1:0] konst_nx;
  logic               last_byte;

  assign at_start = (idx_q == 4'd0);
  assign head_cur = at_start ? byte_in : head_q;

  insn_head_decode head_dec_i (
    .head    (head_cur),
    .cls     (cls_cur),
    .fn      (fn_cur),
    .len     (len_cur),
    .has_reg (has_reg_cur),
    .err     (err_cur)
  );

  assign in_reg_slot   = !at_start && has_reg_cur && (idx_q == 4'd1);
  assign in_const_slot = !at_start && !in_reg_slot;
  assign const_k       = 3'(idx_q[2:0] - (has_reg_cur ? 3'd2 : 3'd1));

  always_comb begin
    regs_nx    = at_start ? {NO_REG, NO_REG} : (in_reg_slot ? byte_in : regs_q);
    konst_base = at_start ? '0 : konst_q;
    konst_nx   = konst_base;
    if (in_const_slot)
      konst_nx = konst_base | ({{(CONST_W-8){1'b0}}, byte_in} << {const_k, 3'b000});
  end

  assign last_byte = (idx_q == 4'(len_cur - 4'd1));
  assign fin       = take && last_byte;

  assign rec = '{cls: cls_cur, fn: fn_cur, ra: regs_nx[7:4], rb: regs_nx[3:0],
                 konst: konst_nx, len: len_cur, err: err_cur};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= 4'd0;
      head_q  <= 8'h00;
      regs_q  <= {NO_REG, NO_REG};
      konst_q <= '0;
    end else if (take) begin
      idx_q   <= last_byte ? 4'd0 : 4'(idx_q + 4'd1);
      head_q  <= head_cur;
      regs_q  <= regs_nx;
      konst_q <= konst_nx;
    end
  end

  // R2: a partly collected instruction never indexes past its own length
  assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != 4'd0) |-> (idx_q < insn_length(head_q[7:4])));

  // R5: a zero leading byte completes on its own byte
  assert_zero_byte_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && at_start && byte_in == 8'h00) |-> fin);
endmodule

// File: rtl/insn_pc_track.sv
module insn_pc_track
  import insn_dec_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);
  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a,
                                                input logic [LEN_W-1:0] l);
    advance = a + ADDR_W'(l);
  endfunction

  logic [ADDR_W-1:0] addr_q;

  assign cur_addr = addr_q;
  assign nxt_addr = advance(addr_q, len);

  always_ff @(posedge clk) begin
    if (!rst_n)    addr_q <= START_ADDR;
    else if (step) addr_q <= nxt_addr;
  end

  // R9: the address only moves when an instruction completes
  assert_addr_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cur_addr));
endmodule

// File: rtl/byte_insn_decoder.sv
module byte_insn_decoder
  import insn_dec_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_class,
  output logic [3:0]        out_func,
  output logic [3:0]        out_ra,
  output logic [3:0]        out_rb,
  output logic [63:0]       out_const,
  output logic [3:0]        out_len,
  output logic              out_err,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ADDR_W-1:0] out_next_addr
);
  logic              take;
  logic              fin;
  insn_rec_t         rec_nx;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;

  insn_rec_t         rec_q;
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] next_q;

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  insn_byte_assembler asm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .byte_in (in_byte),
    .fin     (fin),
    .rec     (rec_nx)
  );

  insn_pc_track #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) pc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (fin),
    .len      (rec_nx.len),
    .cur_addr (cur_addr),
    .nxt_addr (nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rec_q   <= '0;
      addr_q  <= '0;
      next_q  <= '0;
    end else if (fin) begin
      valid_q <= 1'b1;
      rec_q   <= rec_nx;
      addr_q  <= cur_addr;
      next_q  <= nxt_addr;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid     = valid_q;
  assign out_class     = rec_q.cls;
  assign out_func      = rec_q.fn;
  assign out_ra        = rec_q.ra;
  assign out_rb        = rec_q.rb;
  assign out_const     = rec_q.konst;
  assign out_len       = rec_q.len;
  assign out_err       = rec_q.err;
  assign out_addr      = addr_q;
  assign out_next_addr = next_q;

  assert_stall_blocks_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_holds_record_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_class) && $stable(out_func)
      && $stable(out_ra) && $stable(out_rb) && $stable(out_const) && $stable(out_len)
      && $stable(out_addr)));

  assert_len_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len == 4'd1 || out_len == 4'd2 || out_len == 4'd9 || out_len == 4'd10));

  assert_high_class_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class > 4'hB) |-> out_err);

  assert_halt_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 4'h0) |-> (out_len == 4'd1));

  assert_pulse_needs_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !take) |=> !out_valid);
endmodule

// File: tb/byte_insn_decoder_tb_top.sv
`timescale 1ns/1ps
module byte_insn_decoder_tb_top;
  localparam int          AW    = 64;
  localparam logic [63:0] START = 64'h0000_0000_0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_err;
  logic [3:0] out_class, out_func, out_ra, out_rb, out_len;
  logic [63:0] out_const;
  logic [AW-1:0] out_addr, out_next_addr;

  always #10 clk = ~clk;

  byte_insn_decoder #(.ADDR_W(AW), .START_ADDR(START)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class), .out_func(out_func),
    .out_ra(out_ra), .out_rb(out_rb), .out_const(out_const), .out_len(out_len),
    .out_err(out_err), .out_addr(out_addr), .out_next_addr(out_next_addr)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0]  e_head [0:511];
  logic [7:0]  e_regs [0:511];
  logic [63:0] e_cst  [0:511];
  logic [63:0] e_addr [0:511];
  int wr = 0;
  int rd = 0;
  logic [63:0] run_addr = START;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int blen(input logic [3:0] c);
    if (c == 4'h3 || c == 4'h4 || c == 4'h5) return 10;
    if (c == 4'h7 || c == 4'h8) return 9;
    if (c == 4'h2 || c == 4'h6 || c == 4'hA || c == 4'hB) return 2;
    return 1;
  endfunction

  function automatic bit bhasreg(input logic [3:0] c);
    return (c >= 4'h2 && c <= 4'h6) || c == 4'hA || c == 4'hB;
  endfunction

  function automatic bit berr(input logic [3:0] c, input logic [3:0] f);
    int lim;
    if (c >= 4'hC) return 1'b1;
    lim = (c == 4'h2 || c == 4'h7) ? 6 : ((c == 4'h6) ? 3 : 0);
    return int'(f) > lim;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    #5;
    while (!in_ready) begin
      @(negedge clk);
      #5;
    end
    @(posedge clk);
  endtask

  task automatic send_insn(input logic [7:0] head, input logic [7:0] regb, input logic [63:0] cv);
    int n;
    n = blen(head[7:4]);
    e_head[wr] = head;
    e_regs[wr] = bhasreg(head[7:4]) ? regb : 8'hFF;
    e_cst[wr]  = (n >= 9) ? cv : 64'h0;
    e_addr[wr] = run_addr;
    run_addr   = run_addr + 64'(n);
    wr++;
    send_byte(head);
    if (bhasreg(head[7:4])) send_byte(regb);
    if (n >= 9)
      for (int j = 0; j < 8; j++) send_byte(cv[8*j +: 8]);
  endtask

  task automatic drop();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // record monitor, samples mid-low-phase
  always @(negedge clk) begin
    #5;
    if (rst_n && out_valid && out_ready) begin
      if (rd >= wr) begin
        chk("R7 unexpected record", 64'(rd), 64'(wr - 1));
      end else begin
        chk("R1 class/func", {56'h0, out_class, out_func}, {56'h0, e_head[rd]});
        chk("R2 length", 64'(out_len), 64'(blen(e_head[rd][7:4])));
        chk("R3 registers", {56'h0, out_ra, out_rb}, {56'h0, e_regs[rd]});
        chk("R4 constant", out_const, e_cst[rd]);
        chk("R6 error flag", 64'(out_err), 64'(berr(e_head[rd][7:4], e_head[rd][3:0])));
        chk("R9 address", out_addr, e_addr[rd]);
        chk("R9 next address", out_next_addr, e_addr[rd] + 64'(blen(e_head[rd][7:4])));
        if (e_head[rd] == 8'h00)
          chk("R5 zero byte halt", {59'h0, out_class, out_err}, 64'h0);
        rd++;
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #5;
    chk("R10 reset out_valid", 64'(out_valid), 64'h0);
    chk("R10 reset in_ready", 64'(in_ready), 64'h1);
    @(negedge clk);
    rst_n = 1'b1;

    // full sweep of leading bytes, back to back, downstream always ready
    for (int b = 0; b < 256; b++) begin
      logic [63:0] cv;
      for (int j = 0; j < 8; j++) cv[8*j +: 8] = 8'(b + 16*j + 3);
      send_insn(8'(b), 8'(b * 37 + 11), cv);
    end
    drop();
    repeat (3) @(negedge clk);

    // R7: single-cycle pulse after a lone 1-byte instruction
    e_head[wr] = 8'h90; e_regs[wr] = 8'hFF; e_cst[wr] = 64'h0; e_addr[wr] = run_addr;
    run_addr = run_addr + 64'd1; wr++;
    in_valid = 1'b1; in_byte = 8'h90;
    @(negedge clk);
    in_valid = 1'b0;
    #5;
    chk("R7 pulse rises", 64'(out_valid), 64'h1);
    @(negedge clk);
    #5;
    chk("R7 pulse falls", 64'(out_valid), 64'h0);

    // R8: backpressure holds record and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    send_insn(8'h61, 8'h23, 64'h0);
    e_head[wr] = 8'h10; e_regs[wr] = 8'hFF; e_cst[wr] = 64'h0; e_addr[wr] = run_addr;
    run_addr = run_addr + 64'd1; wr++;
    @(negedge clk);
    in_valid = 1'b1; in_byte = 8'h10;
    #5;
    chk("R8 in_ready low", 64'(in_ready), 64'h0);
    chk("R8 record held", {48'h0, out_class, out_func, out_ra, out_rb}, 64'h6123);
    repeat (3) @(negedge clk);
    #5;
    chk("R8 still blocked", 64'(in_ready), 64'h0);
    chk("R8 still held", {47'h0, out_valid, out_class, out_func, out_ra, out_rb}, 64'h1_6123);
    @(negedge clk);
    out_ready = 1'b1;
    #5;
    chk("R8 released", 64'(in_ready), 64'h1);
    @(posedge clk);
    drop();
    repeat (4) @(negedge clk);
    #6;
    chk("R7 all records seen", 64'(rd), 64'(wr));
    done = 1;
    summary();
    $finish;
  end
endmodule